// File: doc/BRIEF.md
# Lavet Clock Motor Pulse Generator

This block produces the coil drive for the two-pin stepping motor of an analog clock movement. A one-cycle request starts a tick. The request carries a tick kind, which is normal, fast-forward or reverse, and the present second-hand position. The block drives the two coil pins one at a time. Each pulse is chopped with a fixed-period PWM, so that a logic-level supply looks like a much lower coil voltage. The coil polarity alternates from one tick to the next.

All pulse lengths, on-times and the reverse region bounds are configuration inputs. The request snapshots them, and they stay fixed until that tick ends. The time base is an external enable that pulses once per microsecond. A PWM window is `PWM_PERIOD` such pulses, and a millisecond is `PERIODS_PER_MS` windows.

A forward tick (normal or fast-forward) is one chopped pulse on the pin for the current polarity. A reverse tick has three phases: a short pulse on the opposite pin, an undriven gap, then a long pulse on the forward pin. The reverse strength comes from one of two parameter sets, and the set is picked by where the second hand sits on the dial. Typical values are a 31 ms normal pulse at 60 µs on per 100 µs, a 32 ms fast-forward pulse at 60 µs, and a reverse of 10/7/28 ms at 90 µs (set A) or 82 µs (set B). A whole tick never runs past a fixed budget of `BUDGET_MS` milliseconds (60 by default).

Top module: `lavet_pulse_gen`

## Requirements
- R1: After reset both coil pins, busy and done are low. The first tick after reset drives coil1 as its forward pin.
- R2: In a driving phase, the active pin is high for the first on-time µs of every `PWM_PERIOD`-µs window and low for the rest of it. Windows are counted from the start of the phase.
- R3: A tick kind of 0 (normal), and also the unused code 3, gives one pulse of normMs ms with normOn on-time on the forward pin.
- R4: Tick kind 1 (fast-forward) gives one pulse of fwdMs ms with fwdOn on-time on the forward pin.
- R5: Tick kind 2 (reverse) drives the short length on the pin opposite the forward pin. It then drives nothing for the gap length, then drives the long length on the forward pin.
- R6: A reverse tick uses set A when regionLo ≤ secPos < regionHi, and set B otherwise. This includes the cases secPos = regionLo and secPos = regionHi.
- R7: The forward pin swaps after every completed tick, reverse ticks included. Polarity 0 selects coil1 as the forward pin and coil2 as the opposite pin.
- R8: The two coil pins are never high together, and both are low while busy is low.
- R9: Busy rises in the cycle after an accepted request. Busy then stays high for exactly as many µs-enable pulses as the tick length. Done is high for one cycle, in the first cycle in which busy is low again.
- R10: A request made while busy is ignored. The running waveform is not restarted, and no extra tick or polarity change follows.
- R11: A tick ends at the millisecond boundary where its elapsed time reaches `BUDGET_MS`, even if the configured phases are longer.
- R12: A configured phase length of 0 ms lasts 1 ms.
- R13: The configuration inputs are captured when a request is accepted. Changes made to them during a tick do not alter that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle enable, once per microsecond |
| tickReq | input | 1 | One-cycle tick request |
| tickType | input | 2 | 0 normal, 1 fast-forward, 2 reverse, 3 as normal |
| secPos | input | POS_W | Second-hand position, 0 to 59 |
| regionLo | input | POS_W | Lower bound (inclusive) of the set-A region |
| regionHi | input | POS_W | Upper bound (exclusive) of the set-A region |
| normMs | input | MS_W | Normal pulse length, ms |
| normOn | input | ON_W | Normal PWM on-time, µs |
| fwdMs | input | MS_W | Fast-forward pulse length, ms |
| fwdOn | input | ON_W | Fast-forward PWM on-time, µs |
| revAShortMs | input | MS_W | Set A short pulse, ms |
| revAGapMs | input | MS_W | Set A gap, ms |
| revALongMs | input | MS_W | Set A long pulse, ms |
| revAOn | input | ON_W | Set A PWM on-time, µs |
| revBShortMs | input | MS_W | Set B short pulse, ms |
| revBGapMs | input | MS_W | Set B gap, ms |
| revBLongMs | input | MS_W | Set B long pulse, ms |
| revBOn | input | ON_W | Set B PWM on-time, µs |
| coil1 | output | 1 | Coil pin 1 drive |
| coil2 | output | 1 | Coil pin 2 drive |
| busy | output | 1 | Tick in progress |
| done | output | 1 | One-cycle end-of-tick pulse |

## Verification
The bench tries the main function with several tick patterns:
- Normal, fast-forward and code-3 ticks, with distinct lengths and on-times. These separate the parameter selection for each kind and show the alternating forward pin.
- Reverse ticks at secPos 34, 35, 54 and 55. These separate set A from set B at both region edges, and check the opposite-pin short pulse against the forward-pin long pulse.
- Sparse µs enables, which show that all timing follows the enable rather than the clock.
- Requests held across the end of a tick, and requests raised mid-tick. These separate back-to-back acceptance from ignored requests.
- Over-long and zero-length settings, and configuration changes made mid-tick. These expose the budget cap, the 1 ms minimum and the snapshot of the configuration.

// File: rtl/lavet_pkg.sv
package lavet_pkg;

  typedef enum logic [1:0] {
    KIND_NORMAL = 2'd0,
    KIND_FAST   = 2'd1,
    KIND_BACK   = 2'd2
  } tick_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHORT = 2'd1,
    PH_GAP   = 2'd2,
    PH_LONG  = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   run;
    logic   phaseRestart;
    logic   togglePol;
    logic   driveEn;
    logic   driveOpp;
    phase_e phaseSel;
  } ctrl_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic phaseLast;
    logic budgetLast;
  } dp_status_t;

endpackage

// File: rtl/lavet_ctrl.sv
module lavet_ctrl
  import lavet_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickReq,
  input  logic         isRev,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         busy,
  output logic         done
);

  phase_e state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      PH_IDLE: begin
        if (tickReq) begin
          strobe.load = 1'b1;
          nextState   = isRev ? PH_SHORT : PH_LONG;
        end
      end
      PH_SHORT: begin
        strobe.run      = 1'b1;
        strobe.driveEn  = 1'b1;
        strobe.driveOpp = 1'b1;
        strobe.phaseSel = PH_SHORT;
        if (status.budgetLast) begin
          strobe.togglePol = 1'b1;
          nextState        = PH_IDLE;
        end else if (status.phaseLast) begin
          strobe.phaseRestart = 1'b1;
          nextState           = PH_GAP;
        end
      end
      PH_GAP: begin
        strobe.run      = 1'b1;
        strobe.phaseSel = PH_GAP;
        if (status.budgetLast) begin
          strobe.togglePol = 1'b1;
          nextState        = PH_IDLE;
        end else if (status.phaseLast) begin
          strobe.phaseRestart = 1'b1;
          nextState           = PH_LONG;
        end
      end
      default: begin
        strobe.run      = 1'b1;
        strobe.driveEn  = 1'b1;
        strobe.phaseSel = PH_LONG;
        if (status.budgetLast || status.phaseLast) begin
          strobe.togglePol = 1'b1;
          nextState        = PH_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state != PH_IDLE) && (nextState == PH_IDLE);
    end
  end

  assign busy = (state != PH_IDLE);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.load);

  // R5
  gap_follows_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_GAP) |-> ($past(state) == PH_SHORT || $past(state) == PH_GAP));

endmodule

// File: rtl/lavet_dp.sv
module lavet_dp
  import lavet_pkg::*;
#(
  parameter int PWM_PERIOD     = 100,
  parameter int PERIODS_PER_MS = 10,
  parameter int BUDGET_MS      = 60,
  parameter int POS_W          = 6,
  parameter int MS_W           = 6,
  parameter int ON_W           = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  ctrl_strobe_t     strobe,
  input  logic [1:0]       tickType,
  input  logic [POS_W-1:0] secPos,
  input  logic [POS_W-1:0] regionLo,
  input  logic [POS_W-1:0] regionHi,
  input  logic [MS_W-1:0]  normMs,
  input  logic [ON_W-1:0]  normOn,
  input  logic [MS_W-1:0]  fwdMs,
  input  logic [ON_W-1:0]  fwdOn,
  input  logic [MS_W-1:0]  revAShortMs,
  input  logic [MS_W-1:0]  revAGapMs,
  input  logic [MS_W-1:0]  revALongMs,
  input  logic [ON_W-1:0]  revAOn,
  input  logic [MS_W-1:0]  revBShortMs,
  input  logic [MS_W-1:0]  revBGapMs,
  input  logic [MS_W-1:0]  revBLongMs,
  input  logic [ON_W-1:0]  revBOn,
  output dp_status_t       status,
  output logic             coil1,
  output logic             coil2
);

  localparam int US_W  = $clog2(PWM_PERIOD + 1);
  localparam int PER_W = $clog2(PERIODS_PER_MS + 1);
  localparam int BUD_W = $clog2(BUDGET_MS + 1);
  localparam logic [US_W-1:0]  US_LAST  = US_W'(PWM_PERIOD - 1);
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIODS_PER_MS - 1);

  logic [US_W-1:0]  usCnt;
  logic [PER_W-1:0] perCnt;
  logic [MS_W-1:0]  msCnt;
  logic [BUD_W-1:0] totMs;
  logic [MS_W-1:0]  lenShort, lenGap, lenLong;
  logic [ON_W-1:0]  onTime;
  logic             pol;

  // parameter-set selection at capture time
  logic             inRegionA;
  logic             kindRev, kindFast;
  logic [MS_W-1:0]  selShort, selGap, selLong;
  logic [ON_W-1:0]  selOn;

  assign inRegionA = (secPos >= regionLo) && (secPos < regionHi);
  assign kindRev   = (tickType == KIND_BACK);
  assign kindFast  = (tickType == KIND_FAST);

  always_comb begin
    selShort = '0;
    selGap   = '0;
    if (kindRev) begin
      selShort = inRegionA ? revAShortMs : revBShortMs;
      selGap   = inRegionA ? revAGapMs   : revBGapMs;
      selLong  = inRegionA ? revALongMs  : revBLongMs;
      selOn    = inRegionA ? revAOn      : revBOn;
    end else if (kindFast) begin
      selLong  = fwdMs;
      selOn    = fwdOn;
    end else begin
      selLong  = normMs;
      selOn    = normOn;
    end
  end

  // timing status
  logic             usWrap, perWrap, msEdge;
  logic [MS_W-1:0]  curLen;
  logic [MS_W:0]    msNext;

  assign usWrap  = (usCnt == US_LAST);
  assign perWrap = (perCnt == PER_LAST);
  assign msEdge  = strobe.run && usTick && usWrap && perWrap;
  assign msNext  = {1'b0, msCnt} + 1'b1;

  always_comb begin
    case (strobe.phaseSel)
      PH_SHORT: curLen = lenShort;
      PH_GAP:   curLen = lenGap;
      default:  curLen = lenLong;
    endcase
  end

  assign status.phaseLast  = msEdge && (msNext >= {1'b0, curLen});
  assign status.budgetLast = msEdge && ((int'(totMs) + 1) >= BUDGET_MS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usCnt    <= '0;
      perCnt   <= '0;
      msCnt    <= '0;
      totMs    <= '0;
      lenShort <= '0;
      lenGap   <= '0;
      lenLong  <= '0;
      onTime   <= '0;
      pol      <= 1'b0;
    end else begin
      if (strobe.load) begin
        usCnt    <= '0;
        perCnt   <= '0;
        msCnt    <= '0;
        totMs    <= '0;
        lenShort <= selShort;
        lenGap   <= selGap;
        lenLong  <= selLong;
        onTime   <= selOn;
      end else if (strobe.run && usTick) begin
        if (usWrap) begin
          usCnt <= '0;
          if (perWrap) begin
            perCnt <= '0;
            totMs  <= totMs + 1'b1;
            msCnt  <= strobe.phaseRestart ? '0 : msCnt + 1'b1;
          end else begin
            perCnt <= perCnt + 1'b1;
          end
        end else begin
          usCnt <= usCnt + 1'b1;
        end
      end
      if (strobe.togglePol) pol <= ~pol;
    end
  end

  // chopped coil drive
  logic pinOn, pinSel;
  assign pinOn  = strobe.driveEn && (int'(usCnt) < int'(onTime));
  assign pinSel = pol ^ strobe.driveOpp;
  assign coil1  = pinOn && !pinSel;
  assign coil2  = pinOn && pinSel;

  // R11
  budget_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (int'(totMs) < BUDGET_MS));

  // R13
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && $past(strobe.run)) |-> ($stable(onTime) && $stable(lenLong)));

endmodule

// File: rtl/lavet_pulse_gen.sv
module lavet_pulse_gen
  import lavet_pkg::*;
#(
  parameter int PWM_PERIOD     = 100,
  parameter int PERIODS_PER_MS = 10,
  parameter int BUDGET_MS      = 60,
  parameter int POS_W          = 6,
  parameter int MS_W           = 6,
  parameter int ON_W           = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  logic             tickReq,
  input  logic [1:0]       tickType,
  input  logic [POS_W-1:0] secPos,
  input  logic [POS_W-1:0] regionLo,
  input  logic [POS_W-1:0] regionHi,
  input  logic [MS_W-1:0]  normMs,
  input  logic [ON_W-1:0]  normOn,
  input  logic [MS_W-1:0]  fwdMs,
  input  logic [ON_W-1:0]  fwdOn,
  input  logic [MS_W-1:0]  revAShortMs,
  input  logic [MS_W-1:0]  revAGapMs,
  input  logic [MS_W-1:0]  revALongMs,
  input  logic [ON_W-1:0]  revAOn,
  input  logic [MS_W-1:0]  revBShortMs,
  input  logic [MS_W-1:0]  revBGapMs,
  input  logic [MS_W-1:0]  revBLongMs,
  input  logic [ON_W-1:0]  revBOn,
  output logic             coil1,
  output logic             coil2,
  output logic             busy,
  output logic             done
);

  ctrl_strobe_t strobe;
  dp_status_t   status;

  lavet_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickReq (tickReq),
    .isRev   (tickType == KIND_BACK),
    .status  (status),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  lavet_dp #(
    .PWM_PERIOD     (PWM_PERIOD),
    .PERIODS_PER_MS (PERIODS_PER_MS),
    .BUDGET_MS      (BUDGET_MS),
    .POS_W          (POS_W),
    .MS_W           (MS_W),
    .ON_W           (ON_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .usTick      (usTick),
    .strobe      (strobe),
    .tickType    (tickType),
    .secPos      (secPos),
    .regionLo    (regionLo),
    .regionHi    (regionHi),
    .normMs      (normMs),
    .normOn      (normOn),
    .fwdMs       (fwdMs),
    .fwdOn       (fwdOn),
    .revAShortMs (revAShortMs),
    .revAGapMs   (revAGapMs),
    .revALongMs  (revALongMs),
    .revAOn      (revAOn),
    .revBShortMs (revBShortMs),
    .revBGapMs   (revBGapMs),
    .revBLongMs  (revBLongMs),
    .revBOn      (revBOn),
    .status      (status),
    .coil1       (coil1),
    .coil2       (coil2)
  );

  // R8
  coils_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(coil1 && coil2));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!coil1 && !coil2));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(tickReq));

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($fell(busy) && !busy));

endmodule

// File: tb/lavet_pulse_gen_tb.sv
module lavet_pulse_gen_tb;

  localparam int BUD = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       usTick = 1'b1;
  logic       tickReq = 1'b0;
  logic [1:0] tickType = 2'd0;
  logic [5:0] secPos = 6'd0, regionLo = 6'd35, regionHi = 6'd55;
  logic [5:0] normMs = 6'd2, fwdMs = 6'd3;
  logic [6:0] normOn = 7'd60, fwdOn = 7'd40;
  logic [5:0] revAShortMs = 6'd1, revAGapMs = 6'd1, revALongMs = 6'd2;
  logic [6:0] revAOn = 7'd90;
  logic [5:0] revBShortMs = 6'd2, revBGapMs = 6'd1, revBLongMs = 6'd1;
  logic [6:0] revBOn = 7'd82;
  logic       coil1, coil2, busy, done;

  lavet_pulse_gen #(.BUDGET_MS(BUD)) u_dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .tickReq(tickReq),
    .tickType(tickType), .secPos(secPos), .regionLo(regionLo),
    .regionHi(regionHi), .normMs(normMs), .normOn(normOn), .fwdMs(fwdMs),
    .fwdOn(fwdOn), .revAShortMs(revAShortMs), .revAGapMs(revAGapMs),
    .revALongMs(revALongMs), .revAOn(revAOn), .revBShortMs(revBShortMs),
    .revBGapMs(revBGapMs), .revBLongMs(revBLongMs), .revBOn(revBOn),
    .coil1(coil1), .coil2(coil2), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  int    vectors = 0;
  int    fails = 0;
  int    doneSeen = 0;
  int    ticksExp = 0;
  int    cycles = 0;
  bit    finished = 0;
  bit    sparse = 0;
  int    divCnt = 0;
  string reqTag = "R1";

  // reference model state
  bit mBusy = 0, mDone = 0, mPol = 0, mRev = 0;
  int mUs = 0, mS = 0, mG = 0, mL = 0, mOn = 0, mTotal = 0;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(negedge clk) begin
    divCnt++;
    usTick <= sparse ? (divCnt % 3 == 0) : 1'b1;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mPol = 0; mUs = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        if (usTick) mUs++;
        if (mUs == mTotal) begin
          mBusy = 0; mDone = 1; mPol = ~mPol;
        end
      end else if (tickReq) begin
        bit inA;
        inA  = (secPos >= regionLo) && (secPos < regionHi);
        mRev = (tickType == 2'd2);
        if (mRev) begin
          mS  = eff(inA ? revAShortMs : revBShortMs);
          mG  = eff(inA ? revAGapMs : revBGapMs);
          mL  = eff(inA ? revALongMs : revBLongMs);
          mOn = inA ? revAOn : revBOn;
        end else begin
          mS = 0; mG = 0;
          mL  = eff(tickType == 2'd1 ? fwdMs : normMs);
          mOn = (tickType == 2'd1) ? fwdOn : normOn;
        end
        mTotal = mS + mG + mL;
        if (mTotal > BUD) mTotal = BUD;
        mTotal = mTotal * 1000;
        mBusy = 1; mUs = 0;
      end
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit e1, e2, on;
      int ms, drv;
      e1 = 0; e2 = 0; drv = 0;
      if (mBusy) begin
        ms = mUs / 1000;
        if (mRev && ms < mS) drv = 2;
        else if (mRev && ms < mS + mG) drv = 0;
        else drv = 1;
        on = (mUs % 100) < mOn;
        if (on && drv != 0) begin
          if ((drv == 1) ^ mPol) e1 = 1; else e2 = 1;
        end
      end
      vectors++;
      if (done) doneSeen++;
      if ({coil1, coil2, busy, done} !== {e1, e2, mBusy, mDone}) begin
        fails++;
        $display("FAIL %s: coil1 coil2 busy done = %b%b%b%b expected %b%b%b%b at us %0d",
                 reqTag, coil1, coil2, busy, done, e1, e2, mBusy, mDone, mUs);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitIdle();
    while (mBusy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runTick(input logic [1:0] kind, input logic [5:0] pos, input string tag);
    reqTag = tag;
    @(negedge clk);
    tickType = kind; secPos = pos; tickReq = 1'b1;
    @(negedge clk);
    tickReq = 1'b0;
    ticksExp++;
    waitIdle();
  endtask

  task automatic finish();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check(coil1 == 0 && coil2 == 0, "R1 coils after reset", {30'd0, coil1, coil2}, 0);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(done == 0, "R1 done after reset", done, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    runTick(2'd0, 6'd0, "R1 R2 R3 normal on coil1");
    runTick(2'd0, 6'd0, "R7 normal on coil2");
    runTick(2'd1, 6'd0, "R4 fast-forward");
    runTick(2'd3, 6'd0, "R3 code 3 as normal");
    runTick(2'd2, 6'd35, "R5 R6 reverse set A at lower edge");
    runTick(2'd2, 6'd34, "R6 reverse set B below region");
    runTick(2'd2, 6'd54, "R6 reverse set A at top");
    runTick(2'd2, 6'd55, "R6 reverse set B at upper edge");

    // R10: request raised mid-tick is ignored
    reqTag = "R10 request while busy";
    @(negedge clk);
    tickType = 2'd0; tickReq = 1'b1;
    @(negedge clk);
    tickReq = 1'b0; ticksExp++;
    repeat (700) @(negedge clk);
    tickType = 2'd2; tickReq = 1'b1;
    repeat (3) @(negedge clk);
    tickReq = 1'b0;
    waitIdle();

    // R13: config change mid-tick has no effect
    reqTag = "R13 capture at accept";
    @(negedge clk);
    tickType = 2'd0; tickReq = 1'b1;
    @(negedge clk);
    tickReq = 1'b0; ticksExp++;
    repeat (300) @(negedge clk);
    normOn = 7'd10; normMs = 6'd5;
    waitIdle();
    normOn = 7'd60; normMs = 6'd2;

    // R11: budget cap on forward and reverse
    fwdMs = 6'd20;
    runTick(2'd1, 6'd0, "R11 forward capped");
    fwdMs = 6'd3;
    revBShortMs = 6'd3; revBGapMs = 6'd3; revBLongMs = 6'd9;
    runTick(2'd2, 6'd10, "R11 reverse capped in long");
    revBShortMs = 6'd20;
    runTick(2'd2, 6'd10, "R11 reverse capped in short");
    revBShortMs = 6'd2; revBGapMs = 6'd1; revBLongMs = 6'd1;

    // R12: zero lengths
    normMs = 6'd0;
    runTick(2'd0, 6'd0, "R12 zero normal length");
    normMs = 6'd2;
    revAGapMs = 6'd0;
    runTick(2'd2, 6'd40, "R12 zero gap");
    revAGapMs = 6'd1;

    // R9: sparse microsecond enable
    sparse = 1; normMs = 6'd1;
    runTick(2'd0, 6'd0, "R9 sparse enable");
    sparse = 0; normMs = 6'd2;

    // R7 R9: request held across back-to-back ticks
    reqTag = "R7 back-to-back";
    @(negedge clk);
    tickType = 2'd1; tickReq = 1'b1;
    while (!mBusy) @(negedge clk);
    while (mBusy) @(negedge clk);
    while (!mBusy) @(negedge clk);
    tickReq = 1'b0; ticksExp += 2;
    waitIdle();

    repeat (5) @(negedge clk);
    check(doneSeen == ticksExp, "R9 R10 done pulse count", doneSeen, ticksExp);
    finish();
  end

endmodule